// File: doc/BRIEF.md
# Shift-and-Add Integer Execution Unit

This unit is a single-stage 64-bit integer execution slice that scales one register operand by a small power of two and adds it to a second operand. The scale comes from a 2-bit immediate, and the shift applied is always that immediate plus one, so it ranges from 1 to 4 bit positions. The result can serve as an address or as an index computation.

An 8-bit operation code selects one of three forms. The doubleword form shifts the whole second operand. The signed-word form first sign-extends the low 32 bits of the second operand. The unsigned-word form first zero-extends them. A record bit asks for a 4-bit condition field built from the result. Any operation code that matches none of the forms is flagged as illegal.

All outputs are registered once, so a result appears one clock after the input strobe.

Top module: `shadd_unit`

## Requirements
- R1: With op code 8'b01101110 (doubleword form), result = (src_b << (shift_imm + 1)) + src_a, where shift_imm 0..3 gives a shift of 1..4.
- R2: With op code 8'b10101110 (signed-word form), src_b[31:0] is sign-extended from bit 31 to 64 bits before the shift and the add.
- R3: With op code 8'b11101110 (unsigned-word form), src_b[31:0] is zero-extended to 64 bits before the shift and the add.
- R4: The shift fills the vacated low bits with zeros and drops the bits above bit 63. The sum is taken modulo 2^64, and any carry out is lost.
- R5: cr_we is 1 in the output cycle only when the operation was legal and rec was 1. When rec is 0, cr_we stays 0.
- R6: cr_field[3] is LT (result negative as a signed number), cr_field[2] is GT (result positive and nonzero), cr_field[1] is EQ (result zero) and cr_field[0] copies so_in.
- R7: out_valid is in_valid delayed by exactly one clock. When in_valid is low, out_valid is low in the next cycle.
- R8: An op code that matches none of the three forms gives illegal = 1 for one cycle together with out_valid, result = 0 and cr_we = 0.
- R9: A synchronous active-high rst clears out_valid, cr_we and illegal at the next clock edge.
- R10: With src_a = 0xf00dcafedeadbeef, src_b = 0xabadbabedefec8ed and shift_imm = 0, the signed-word form gives ((0xffffffffdefec8ed << 1) + src_a) mod 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operation strobe |
| src_a | input | 64 | Addend operand |
| src_b | input | 64 | Operand to be shifted |
| shift_imm | input | 2 | Shift immediate; the shift applied is this value plus one |
| op_code | input | 8 | Form selector |
| rec | input | 1 | Request for a condition-field write |
| so_in | input | 1 | Incoming summary-overflow bit |
| result | output | 64 | Registered sum |
| cr_field | output | 4 | Registered condition field {LT, GT, EQ, SO} |
| cr_we | output | 1 | Condition-field write enable |
| out_valid | output | 1 | Output strobe |
| illegal | output | 1 | Unrecognised op code flag |

## Verification
The assertions assume that every input is known whenever in_valid is high. They also assume that rst is held for at least one edge before in_valid is first used, so the previous-cycle terms in the properties are meaningful.

The bench drives every input at the falling edge from defined values and starts only after reset. It sweeps all four shift immediates and all three forms over operand patterns that sit on the sign and carry boundaries. It also runs every one of the 256 op codes with rec set, so each illegal code is covered.

// File: rtl/shadd_unit.sv
module shadd_unit #(
  parameter int XLEN = 64,
  parameter int IMMW = 2,
  parameter int OPW  = 8,
  parameter logic [OPW-1:0] OP_DWORD = 8'b01101110,
  parameter logic [OPW-1:0] OP_SWORD = 8'b10101110,
  parameter logic [OPW-1:0] OP_UWORD = 8'b11101110
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [IMMW-1:0] shift_imm,
  input  logic [OPW-1:0]  op_code,
  input  logic            rec,
  input  logic            so_in,
  output logic [XLEN-1:0] result,
  output logic [3:0]      cr_field,
  output logic            cr_we,
  output logic            out_valid,
  output logic            illegal
);
  localparam int HALF = XLEN / 2;
  localparam int SHW  = IMMW + 1;

  logic            sel_dw, sel_sw, sel_uw, legal;
  logic [XLEN-1:0] b_ext, b_shift, sum;
  logic [SHW-1:0]  sh_amt;
  logic            lt, eq;

  assign sel_dw = (op_code == OP_DWORD);
  assign sel_sw = (op_code == OP_SWORD);
  assign sel_uw = (op_code == OP_UWORD);
  assign legal  = sel_dw | sel_sw | sel_uw;

  assign b_ext   = sel_dw ? src_b
                          : {{HALF{sel_sw & src_b[HALF-1]}}, src_b[HALF-1:0]};
  assign sh_amt  = {1'b0, shift_imm} + SHW'(1);
  assign b_shift = b_ext << sh_amt;
  assign sum     = legal ? (b_shift + src_a) : '0;

  assign lt = sum[XLEN-1];
  assign eq = (sum == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cr_we     <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      cr_we     <= in_valid & legal & rec;
      illegal   <= in_valid & ~legal;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      result   <= sum;
      cr_field <= {lt, ~lt & ~eq, eq, so_in};
    end
  end

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r7_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r5_no_rec_no_write: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rec) |=> !cr_we);
  a_r8_illegal_output: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (out_valid && !cr_we && result == '0));
  a_r6_single_flag: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> $onehot(cr_field[3:1]));
  a_r6_eq_matches: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> (cr_field[1] == (result == '0)));
  a_r6_so_copy: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (cr_field[0] == $past(so_in)));
endmodule

// File: tb/shadd_unit_tb.sv
module shadd_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] src_a = '0, src_b = '0;
  logic [1:0]  shift_imm = '0;
  logic [7:0]  op_code = '0;
  logic        rec = 1'b0, so_in = 1'b0;
  logic [63:0] result;
  logic [3:0]  cr_field;
  logic        cr_we, out_valid, illegal;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadd_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .shift_imm(shift_imm), .op_code(op_code), .rec(rec), .so_in(so_in),
    .result(result), .cr_field(cr_field), .cr_we(cr_we),
    .out_valid(out_valid), .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] sm, input logic [7:0] op,
                        input logic [63:0] a, input logic [63:0] b,
                        input logic r, input logic so, input string tag);
    logic [63:0] bx, exp;
    logic        lg, lt, eq;
    lg = 1'b1;
    if (op == 8'b01101110)      bx = b;
    else if (op == 8'b10101110) bx = {{32{b[31]}}, b[31:0]};
    else if (op == 8'b11101110) bx = {32'h0, b[31:0]};
    else begin bx = '0; lg = 1'b0; end
    exp = lg ? (bx << (sm + 1)) + a : 64'h0;
    lt = exp[63];
    eq = (exp == 64'h0);
    src_a = a; src_b = b; shift_imm = sm; op_code = op; rec = r; so_in = so;
    in_valid = 1'b1;
    @(negedge clk);
    chk({tag, " R7 out_valid"}, 64'(out_valid), 64'h1);
    chk({tag, " result"}, result, exp);
    chk({tag, " R8 illegal"}, 64'(illegal), 64'(!lg));
    chk({tag, " R5 cr_we"}, 64'(cr_we), 64'(lg & r));
    if (lg && r)
      chk({tag, " R6 cr_field"}, 64'(cr_field), 64'({lt, !lt && !eq, eq, so}));
  endtask

  logic [63:0] pats [8];

  initial begin
    pats[0] = 64'h0;
    pats[1] = 64'hffffffffffffffff;
    pats[2] = 64'h0000000080000000;
    pats[3] = 64'h000000007fffffff;
    pats[4] = 64'hf00dcafedeadbeef;
    pats[5] = 64'habadbabedefec8ed;
    pats[6] = 64'h8000000000000001;
    pats[7] = 64'h123456789abcdef0;

    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", 64'(out_valid), 64'h0);
    chk("R9 reset cr_we", 64'(cr_we), 64'h0);
    chk("R9 reset illegal", 64'(illegal), 64'h0);
    rst = 1'b0;
    @(negedge clk);

    run_op(2'd0, 8'b10101110, 64'hf00dcafedeadbeef, 64'habadbabedefec8ed, 1'b1, 1'b0, "R10 vector");
    chk("R10 literal", result, (64'hffffffffdefec8ed << 1) + 64'hf00dcafedeadbeef);

    for (int sm = 0; sm < 4; sm++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          run_op(2'(sm), 8'b01101110, pats[i], pats[j], 1'(j[0]), 1'(i[0]), "R1 R4 dword");
          run_op(2'(sm), 8'b10101110, pats[i], pats[j], 1'(i[0]), 1'(j[1]), "R2 R4 sword");
          run_op(2'(sm), 8'b11101110, pats[i], pats[j], 1'b1, 1'(j[0]), "R3 R4 uword");
        end

    run_op(2'd3, 8'b01101110, 64'h0, 64'hf000000000000001, 1'b1, 1'b0, "R4 dropped top bits");
    run_op(2'd1, 8'b01101110, 64'hffffffffffffffff, 64'h1, 1'b1, 1'b1, "R4 carry lost");

    for (int op = 0; op < 256; op++)
      run_op(2'(op % 4), 8'(op), 64'h5555aaaa5555aaaa, 64'h00000000ffffffff, 1'b1, 1'b1, "R8 opcode sweep");

    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 idle out_valid", 64'(out_valid), 64'h0);
    chk("R5 idle cr_we", 64'(cr_we), 64'h0);

    src_a = 64'h1; src_b = 64'h1; op_code = 8'b01101110; rec = 1'b1; in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    chk("R9 mid reset out_valid", 64'(out_valid), 64'h0);
    chk("R9 mid reset cr_we", 64'(cr_we), 64'h0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule